// File: doc/BRIEF.md
# Processor Mode and Status Flag Unit

This unit owns the 8-bit processor status byte and the emulation bit of a CPU that runs either in an 8-bit compatible mode or in a 16-bit native mode. The instruction sequencer issues one command per cycle. The commands are: exchange carry with the emulation bit, set status bits by a mask, clear status bits by a mask, load the status byte from a pulled stack byte, or replace selected flags with a given value. The unit registers the new status and mode. In the same cycle it raises single-cycle strobes that the register file and the datapath act on.

Three side effects apply to every update. While the emulation bit is 1, the two width flags are pinned to 1. When the index-width flag ends up 1, the index registers' high bytes are cleared. An exchange that leaves the CPU in emulation mode forces the stack pointer back to page one. A separate strobe marks every change of the memory-width flag, the index-width flag or the emulation bit, so the datapath can reselect operand sizes.

Status bit order, from bit 7 down to bit 0, is N, V, M, X, D, I, Z, C. M is the memory/accumulator width flag and X is the index width flag.

Top module: `psw_unit`

## Requirements
- R1: After reset, status is 0x34, emulation bit is 1, and all three strobes are 0.
- R2: A command is taken on a rising clock edge when cmd_valid is 1. Its results appear at the outputs right after that edge. Opcode 1 (exchange) swaps status bit 0 (C) with the emulation bit.
- R3: Whenever the emulation bit is 1 after a command, status bits 5 and 4 (M and X) are 1 after that command. This covers every opcode. An exchange that leaves the emulation bit at 1 pulses stack_page_set for exactly that cycle.
- R4: Opcode 2 ORs cmd_byte into status. Opcode 3 ANDs status with the inverse of cmd_byte.
- R5: Opcode 4 loads status from cmd_byte. In native mode the byte is taken unchanged. In emulation mode it is ORed with 0x30.
- R6: Opcode 5 sets status to (status AND NOT cmd_byte) OR cmd_value.
- R7: idx_hi_clr pulses for one cycle after any command with opcode 1 to 5 whose resulting status has bit 4 (X) set.
- R8: width_chg pulses for one cycle after any command that changes status bit 5, status bit 4 or the emulation bit.
- R9: With cmd_valid at 0, or with opcode 0, 6 or 7, status and the emulation bit hold and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 exchange, 2 set mask, 3 clear mask, 4 load, 5 flag replace |
| cmd_byte | input | 8 | Mask, or the pulled stack byte for a load |
| cmd_value | input | 8 | Replacement bits for opcode 5 |
| status | output | 8 | Registered status byte (N V M X D I Z C) |
| emu | output | 1 | Registered emulation bit |
| idx_hi_clr | output | 1 | Strobe: clear index high bytes |
| stack_page_set | output | 1 | Strobe: force stack high byte to 0x01 |
| width_chg | output | 1 | Strobe: M, X or the emulation bit changed |

## Verification
The bench walks the unit through thousands of commands across both modes, with varied masks and values. It checks every field against an arithmetic model. Four kinds of fault are targeted:
- Clearing M or X in emulation mode. A design that missed the pin would let the widths drop to 16 bits while still in compatible mode.
- Swapping the exchange in one direction only. That would lose the carry or the mode.
- Gating the index-clear strobe on the wrong flag, or on a NOP. That would wipe live index data or leave stale high bytes.
- Failing to flag a width change that came from a load or an exchange. The datapath would then keep the wrong operand size.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int STAT_W = 8;
    localparam int OP_W   = 3;
    localparam int C_BIT  = 0;
    localparam int X_BIT  = 4;
    localparam int M_BIT  = 5;
    localparam logic [STAT_W-1:0] WIDTH_PIN = STAT_W'(1) << X_BIT | STAT_W'(1) << M_BIT;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 3'd0,
        OP_XCHG = 3'd1,
        OP_SETM = 3'd2,
        OP_CLRM = 3'd3,
        OP_LOAD = 3'd4,
        OP_FLAG = 3'd5
    } psw_op_e;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              emu;
        logic              idx_clr;
        logic              stk_set;
        logic              wchg;
    } psw_state_t;
endpackage

// File: rtl/psw_alu.sv
module psw_alu
    import psw_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [STAT_W-1:0] stat_in,
    input  logic              emu_in,
    input  logic [STAT_W-1:0] imm,
    input  logic [STAT_W-1:0] val,
    output logic [STAT_W-1:0] stat_raw,
    output logic              emu_raw,
    output logic              active
);
    always_comb begin
        stat_raw = stat_in;
        emu_raw  = emu_in;
        active   = 1'b1;
        case (op)
            OP_XCHG: begin
                stat_raw[C_BIT] = emu_in;
                emu_raw         = stat_in[C_BIT];
            end
            OP_SETM: stat_raw = stat_in | imm;
            OP_CLRM: stat_raw = stat_in & ~imm;
            OP_LOAD: stat_raw = imm;
            OP_FLAG: stat_raw = (stat_in & ~imm) | val;
            default: active   = 1'b0;
        endcase
    end
endmodule

// File: rtl/psw_fx.sv
module psw_fx
    import psw_pkg::*;
(
    input  logic              active,
    input  logic              is_xchg,
    input  logic [STAT_W-1:0] stat_old,
    input  logic              emu_old,
    input  logic [STAT_W-1:0] stat_raw,
    input  logic              emu_raw,
    output logic [STAT_W-1:0] stat_fin,
    output logic              idx_clr,
    output logic              stk_set,
    output logic              wchg
);
    always_comb begin
        stat_fin = emu_raw ? (stat_raw | WIDTH_PIN) : stat_raw;
        idx_clr  = active && stat_fin[X_BIT];
        stk_set  = active && is_xchg && emu_raw;
        wchg     = active && ({stat_fin[M_BIT], stat_fin[X_BIT], emu_raw} !=
                              {stat_old[M_BIT], stat_old[X_BIT], emu_old});
    end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter logic [7:0] RESET_STATUS = 8'h34,
    parameter logic       RESET_EMU    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic [7:0] cmd_value,
    output logic [7:0] status,
    output logic       emu,
    output logic       idx_hi_clr,
    output logic       stack_page_set,
    output logic       width_chg
);
    psw_state_t        st_d, st_q;
    logic [OP_W-1:0]   op_eff;
    logic [STAT_W-1:0] stat_raw, stat_fin;
    logic              emu_raw, active, fx_idx, fx_stk, fx_wchg;

    assign op_eff = cmd_valid ? cmd_op : OP_W'(OP_NONE);

    psw_alu u_alu (
        .op(op_eff), .stat_in(st_q.stat), .emu_in(st_q.emu),
        .imm(cmd_byte), .val(cmd_value),
        .stat_raw(stat_raw), .emu_raw(emu_raw), .active(active)
    );

    psw_fx u_fx (
        .active(active), .is_xchg(op_eff == OP_W'(OP_XCHG)),
        .stat_old(st_q.stat), .emu_old(st_q.emu),
        .stat_raw(stat_raw), .emu_raw(emu_raw),
        .stat_fin(stat_fin), .idx_clr(fx_idx), .stk_set(fx_stk), .wchg(fx_wchg)
    );

    always_comb begin
        st_d         = st_q;
        st_d.idx_clr = 1'b0;
        st_d.stk_set = 1'b0;
        st_d.wchg    = 1'b0;
        if (active) begin
            st_d.stat    = stat_fin;
            st_d.emu     = emu_raw;
            st_d.idx_clr = fx_idx;
            st_d.stk_set = fx_stk;
            st_d.wchg    = fx_wchg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat    <= RESET_STATUS | (RESET_EMU ? WIDTH_PIN : '0);
            st_q.emu     <= RESET_EMU;
            st_q.idx_clr <= 1'b0;
            st_q.stk_set <= 1'b0;
            st_q.wchg    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status         = st_q.stat;
    assign emu            = st_q.emu;
    assign idx_hi_clr     = st_q.idx_clr;
    assign stack_page_set = st_q.stk_set;
    assign width_chg      = st_q.wchg;

    assert_emu_pins_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        emu |-> (status[M_BIT] && status[X_BIT]));

    assert_xchg_swaps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1) |=>
            (emu == $past(status[C_BIT]) && status[C_BIT] == $past(emu)));

    assert_idx_clr_needs_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_hi_clr |-> status[X_BIT]);

    assert_stack_page_in_emu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stack_page_set |-> emu);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 3'd0 || cmd_op > 3'd5) |=>
            ($stable(status) && $stable(emu) && !idx_hi_clr && !width_chg && !stack_page_set));

    assert_width_chg_real_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != 3'd0 && cmd_op <= 3'd5) |=>
            (width_chg == ({status[M_BIT], status[X_BIT], emu} !=
                           $past({status[M_BIT], status[X_BIT], emu}))));
endmodule

// File: tb/psw_unit_tb.sv
module psw_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] cmd_value = 8'h00;
    logic [7:0] status;
    logic       emu, idx_hi_clr, stack_page_set, width_chg;

    int checks = 0;
    int errors = 0;
    logic [7:0] ms;
    logic       me;

    always #2 clk = ~clk;

    psw_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_value(cmd_value), .status(status), .emu(emu),
        .idx_hi_clr(idx_hi_clr), .stack_page_set(stack_page_set), .width_chg(width_chg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [2:0] op);
        if (!v || op == 3'd0 || op > 3'd5) return "R9";
        case (op)
            3'd1: return "R2";
            3'd2, 3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 status", status, 8'h34);
        chk("R1 emu", emu, 1);
        chk("R1 strobes", {idx_hi_clr, stack_page_set, width_chg}, 0);
        ms = 8'h34;
        me = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            logic v;
            logic [2:0] op;
            logic [7:0] b, val, ns;
            logic ne, act, e_idx, e_stk, e_wc;
            string t;
            v   = (i % 7) != 6;
            op  = 3'((i * 5 + i / 11) % 8);
            b   = 8'((i * 37) ^ (i >> 3));
            val = 8'((i * 91) >> 2) & b;
            if (i % 13 == 0) val = 8'(i);
            @(negedge clk);
            cmd_valid = v; cmd_op = op; cmd_byte = b; cmd_value = val;
            ns = ms; ne = me; act = v && op >= 3'd1 && op <= 3'd5;
            if (act) begin
                case (op)
                    3'd1: begin ns[0] = me; ne = ms[0]; end
                    3'd2: ns = ms | b;
                    3'd3: ns = ms & ~b;
                    3'd4: ns = b;
                    default: ns = (ms & ~b) | val;
                endcase
                if (ne) ns = ns | 8'h30;
            end
            e_idx = act && ns[4];
            e_stk = act && op == 3'd1 && ne;
            e_wc  = act && ({ns[5], ns[4], ne} != {ms[5], ms[4], me});
            @(posedge clk);
            #1;
            t = tag_of(v, op);
            chk({t, " R3 status"}, status, ns);
            chk({t, " emu"}, emu, ne);
            chk("R7 idx_hi_clr", idx_hi_clr, e_idx);
            chk("R3 stack_page_set", stack_page_set, e_stk);
            chk("R8 width_chg", width_chg, e_wc);
            ms = ns;
            me = ne;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 re-reset status", status, 8'h34);
        chk("R1 re-reset emu", emu, 1);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule